// File: doc/BRIEF.md
# DVFS Load-Tracking Request Generator

This block watches how busy a processor is and decides when its clock and voltage setpoint should move. On every sample tick from a programmable divider it forms a load sample. The sample is the weight of a processor-busy input plus the weights of sixteen general-purpose load inputs that are currently high, saturated to six bits. The block then folds the sample into an exponential moving average kept in fixed point.

The six-bit integer part of that average is the load level. It is compared against an upper threshold, a lower threshold and a panic threshold. Runs of consecutive above-upper or below-lower evaluations are counted, and a request fires when a run reaches its programmed length. A panic fires at once. Which directions may fire depends on the current setpoint: low or turbo.

A fired request stays on a two-bit code output with a maskable interrupt until software acknowledges it with a start pulse. After software has applied the change, it closes the request with a finish pulse. Software reprograms the thresholds whenever the setpoint changes.

Top module: `dvfs_load_governor`

## Requirements
- R1: After reset, and while `track_en` is low, `req_code` is 0, `req_irq` is 0 and `load_level` is 0. Code values: 0 none, 1 raise, 2 lower, 3 panic raise.
- R2: With `sum_post_sel` high, the sample is `busy_weight` when `cpu_busy` is high, plus the weight in `gp_weight[4*i+3:4*i]` for every high `gp_in[i]`, saturated at 63. An input whose weight is 0 adds nothing.
- R3: With `sum_post_sel` low, the sample is the busy contribution alone, and the general-purpose inputs are ignored.
- R4: A sample is taken on the (`div_cfg`+1)-th clock edge after `track_en` rises, and then on every further `div_cfg`+1 edges.
- R5: On each sample, the 10-bit average A (4 fraction bits) becomes A + floor((16*S - A) / 2^`ema_shift`). `load_level` is A divided by 16, rounded down. `load_level` changes on no other edge.
- R6: With the setpoint low, a raise request (code 1) fires when `load_level` > `up_thr` on `up_cnt` consecutive evaluations. A non-qualifying evaluation restarts the run.
- R7: With the setpoint turbo, a lower request (code 2) fires when `load_level` < `dn_thr` on `dn_cnt` consecutive evaluations.
- R8: With the setpoint low, a panic request (code 3) fires on the first evaluation where `load_level` > `pnc_thr`. It takes precedence over a raise.
- R9: No code 1 or 3 is raised while `setpoint_turbo` is high, and no code 2 while it is low.
- R10: `req_irq` is high only while a request is waiting for `sw_start` and `req_mask` is low.
- R11: `sw_start` acknowledges a waiting request. While a request is outstanding, `req_code` holds and both run counters freeze. `sw_finish` after the acknowledge clears `req_code` to 0 and both run counters. `sw_finish` before the acknowledge is ignored.
- R12: Dropping `track_en` clears any outstanding request, the counters and the average within one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| track_en | input | 1 | Enables load tracking |
| setpoint_turbo | input | 1 | Current setpoint: 1 turbo, 0 low |
| cpu_busy | input | 1 | Processor busy indication |
| busy_weight | input | 6 | Weight of the busy input |
| gp_in | input | 16 | General-purpose load inputs |
| gp_weight | input | 64 | Four-bit weight per input, input i at bits 4i+3..4i |
| sum_post_sel | input | 1 | 1: full weighted sum, 0: busy contribution only |
| div_cfg | input | 4 | Sample divider, period div_cfg+1 clocks |
| ema_shift | input | 3 | log2 of the averaging length |
| up_thr | input | 6 | Upper threshold |
| dn_thr | input | 6 | Lower threshold |
| pnc_thr | input | 6 | Panic threshold |
| up_cnt | input | 8 | Run length for a raise |
| dn_cnt | input | 8 | Run length for a lower |
| req_mask | input | 1 | Masks the request interrupt |
| sw_start | input | 1 | Software acknowledge pulse |
| sw_finish | input | 1 | Software completion pulse |
| req_code | output | 2 | Frequency-change request code |
| req_irq | output | 1 | Request interrupt |
| load_level | output | 6 | Smoothed load level |

## Verification
A corrupted average shows on `load_level` at the next sample tick. It reaches `req_code` one evaluation later, as a request arriving early, late or never. A run counter that is not cleared or not frozen shows as a request that fires sooner after a finish than the programmed run length allows. This is measured to the exact clock. Gating errors show as a wrong code on the first request raised in the disallowed setpoint. The bench predicts every request in order and flags any code change it did not predict.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int LOAD_W  = 6;
  localparam int FRAC_W  = 4;
  localparam int AVG_W   = LOAD_W + FRAC_W;
  localparam int SHIFT_W = 3;

  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_UP    = 2'd1,
    REQ_DOWN  = 2'd2,
    REQ_PANIC = 2'd3
  } req_code_e;

  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_RAISED = 2'd1,
    HS_ACKED  = 2'd2
  } hs_state_e;

  // One averaging step: move the average toward the sample by 1/2^sh of the gap.
  function automatic logic [AVG_W-1:0] ema_step(
    input logic [AVG_W-1:0]   avg,
    input logic [LOAD_W-1:0]  smp,
    input logic [SHIFT_W-1:0] sh
  );
    logic signed [AVG_W+1:0] gap;
    logic signed [AVG_W+1:0] step;
    gap  = $signed({2'b00, smp, {FRAC_W{1'b0}}}) - $signed({2'b00, avg});
    step = gap >>> sh;
    return avg + step[AVG_W-1:0];
  endfunction
endpackage

// File: rtl/lt_tick_gen.sv
module lt_tick_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!en || tick)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // Ticks are separated by div+1 clocks, so a nonzero divider never ticks twice in a row.
  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/lt_load_sum.sv
module lt_load_sum #(
  parameter int NGP    = 16,
  parameter int WW     = 4,
  parameter int LOAD_W = lt_pkg::LOAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [LOAD_W-1:0] busy_weight,
  input  logic [NGP-1:0]    gp_in,
  input  logic [NGP*WW-1:0] gp_weight,
  input  logic              post_sel,
  output logic [LOAD_W-1:0] sample
);
  localparam int SUM_W = LOAD_W + WW + $clog2(NGP) + 1;
  localparam int MAXL  = (1 << LOAD_W) - 1;

  logic [WW-1:0]     term [NGP];
  logic [LOAD_W-1:0] busy_term;
  logic [SUM_W-1:0]  acc;

  genvar g;
  generate
    for (g = 0; g < NGP; g++) begin : g_term
      assign term[g] = gp_in[g] ? gp_weight[g*WW +: WW] : '0;
    end
  endgenerate

  assign busy_term = busy ? busy_weight : '0;

  always_comb begin
    acc = SUM_W'(busy_term);
    if (post_sel) begin
      for (int i = 0; i < NGP; i++) acc = acc + SUM_W'(term[i]);
    end
    sample = (acc > SUM_W'(MAXL)) ? LOAD_W'(MAXL) : acc[LOAD_W-1:0];
  end

  // The general-purpose terms only ever add, so the sample never falls below the busy part.
  assert_busy_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample >= busy_term);
endmodule

// File: rtl/lt_ema.sv
module lt_ema
  import lt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic [LOAD_W-1:0]  sample,
  input  logic [SHIFT_W-1:0] shift,
  output logic [LOAD_W-1:0]  load
);
  logic [AVG_W-1:0] avg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     avg <= '0;
    else if (!en)   avg <= '0;
    else if (tick)  avg <= ema_step(avg, sample, shift);
  end

  assign load = avg[AVG_W-1:FRAC_W];

  // The average moves only on a sample tick.
  assert_ema_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(tick)) |-> $stable(avg));
endmodule

// File: rtl/lt_decide.sv
module lt_decide
  import lt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              eval,
  input  logic              turbo,
  input  logic [LOAD_W-1:0] load,
  input  logic [LOAD_W-1:0] up_thr,
  input  logic [LOAD_W-1:0] dn_thr,
  input  logic [LOAD_W-1:0] pnc_thr,
  input  logic [CNT_W-1:0]  up_cnt,
  input  logic [CNT_W-1:0]  dn_cnt,
  input  logic              req_mask,
  input  logic              sw_start,
  input  logic              sw_finish,
  output logic [1:0]        req_code,
  output logic              req_irq,
  output logic              fire
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  hs_state_e         state;
  req_code_e         code_q, new_code;
  logic [CNT_W-1:0]  up_ctr, dn_ctr, up_n, dn_n;
  logic              up_hit, dn_hit, pn_hit, up_ok, dn_ok;

  always_comb begin
    up_hit = !turbo && (load > up_thr);
    dn_hit =  turbo && (load < dn_thr);
    pn_hit = !turbo && (load > pnc_thr);
    up_n   = up_hit ? ((up_ctr == CNT_MAX) ? up_ctr : up_ctr + 1'b1) : '0;
    dn_n   = dn_hit ? ((dn_ctr == CNT_MAX) ? dn_ctr : dn_ctr + 1'b1) : '0;
    up_ok  = up_hit && (up_n >= up_cnt);
    dn_ok  = dn_hit && (dn_n >= dn_cnt);
    fire   = (state == HS_IDLE) && eval && (pn_hit || up_ok || dn_ok);
    if (pn_hit)     new_code = REQ_PANIC;
    else if (up_ok) new_code = REQ_UP;
    else            new_code = REQ_DOWN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= HS_IDLE;
      code_q <= REQ_NONE;
      up_ctr <= '0;
      dn_ctr <= '0;
    end else if (!en) begin
      state  <= HS_IDLE;
      code_q <= REQ_NONE;
      up_ctr <= '0;
      dn_ctr <= '0;
    end else begin
      case (state)
        HS_IDLE: begin
          if (fire) begin
            state  <= HS_RAISED;
            code_q <= new_code;
          end else if (eval) begin
            up_ctr <= up_n;
            dn_ctr <= dn_n;
          end
        end
        HS_RAISED: if (sw_start) state <= HS_ACKED;
        HS_ACKED: begin
          if (sw_finish) begin
            state  <= HS_IDLE;
            code_q <= REQ_NONE;
            up_ctr <= '0;
            dn_ctr <= '0;
          end
        end
        default: state <= HS_IDLE;
      endcase
    end
  end

  assign req_code = code_q;
  assign req_irq  = (state == HS_RAISED) && !req_mask;

  // A newly raised code must match the setpoint seen when it fired.
  assert_setpoint_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != REQ_NONE && $past(code_q) == REQ_NONE) |->
      (($past(turbo) && code_q == REQ_DOWN) || (!$past(turbo) && code_q != REQ_DOWN)));

  // An outstanding request keeps its code and freezes both run counters.
  assert_code_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state != HS_IDLE && $past(state) != HS_IDLE) |-> $stable(code_q));

  assert_ctr_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state != HS_IDLE && $past(state) != HS_IDLE) |-> ($stable(up_ctr) && $stable(dn_ctr)));

  // The interrupt only accompanies a real, unmasked code.
  assert_irq_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_irq |-> (code_q != REQ_NONE && !req_mask));
endmodule

// File: rtl/dvfs_load_governor.sv
module dvfs_load_governor
  import lt_pkg::*;
#(
  parameter int NGP   = 16,
  parameter int WW    = 4,
  parameter int CNT_W = 8,
  parameter int DIV_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               track_en,
  input  logic               setpoint_turbo,
  input  logic               cpu_busy,
  input  logic [LOAD_W-1:0]  busy_weight,
  input  logic [NGP-1:0]     gp_in,
  input  logic [NGP*WW-1:0]  gp_weight,
  input  logic               sum_post_sel,
  input  logic [DIV_W-1:0]   div_cfg,
  input  logic [SHIFT_W-1:0] ema_shift,
  input  logic [LOAD_W-1:0]  up_thr,
  input  logic [LOAD_W-1:0]  dn_thr,
  input  logic [LOAD_W-1:0]  pnc_thr,
  input  logic [CNT_W-1:0]   up_cnt,
  input  logic [CNT_W-1:0]   dn_cnt,
  input  logic               req_mask,
  input  logic               sw_start,
  input  logic               sw_finish,
  output logic [1:0]         req_code,
  output logic               req_irq,
  output logic [LOAD_W-1:0]  load_level
);
  logic              sample_tick;
  logic              eval_strobe;
  logic              req_fire;
  logic [LOAD_W-1:0] load_sample;

  lt_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(track_en), .div(div_cfg), .tick(sample_tick)
  );

  lt_load_sum #(.NGP(NGP), .WW(WW), .LOAD_W(LOAD_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .busy(cpu_busy), .busy_weight(busy_weight),
    .gp_in(gp_in), .gp_weight(gp_weight), .post_sel(sum_post_sel),
    .sample(load_sample)
  );

  lt_ema u_ema (
    .clk(clk), .rst_n(rst_n), .en(track_en), .tick(sample_tick),
    .sample(load_sample), .shift(ema_shift), .load(load_level)
  );

  // Evaluate one clock after the sample, when the new average is visible.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eval_strobe <= 1'b0;
    else        eval_strobe <= track_en && sample_tick;
  end

  lt_decide #(.CNT_W(CNT_W)) u_decide (
    .clk(clk), .rst_n(rst_n), .en(track_en), .eval(eval_strobe),
    .turbo(setpoint_turbo), .load(load_level),
    .up_thr(up_thr), .dn_thr(dn_thr), .pnc_thr(pnc_thr),
    .up_cnt(up_cnt), .dn_cnt(dn_cnt), .req_mask(req_mask),
    .sw_start(sw_start), .sw_finish(sw_finish),
    .req_code(req_code), .req_irq(req_irq), .fire(req_fire)
  );

  // A firing decision shows on the code output one clock later.
  assert_fire_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && track_en) |=> (req_code != 2'd0 || !track_en));
endmodule

// File: tb/dvfs_load_governor_test.sv
`timescale 1ns/1ps
module dvfs_load_governor_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        track_en, setpoint_turbo, cpu_busy, sum_post_sel;
  logic [5:0]  busy_weight, up_thr, dn_thr, pnc_thr;
  logic [15:0] gp_in;
  logic [63:0] gp_weight;
  logic [3:0]  div_cfg;
  logic [2:0]  ema_shift;
  logic [7:0]  up_cnt, dn_cnt;
  logic        req_mask, sw_start, sw_finish;
  logic [1:0]  req_code;
  logic        req_irq;
  logic [5:0]  load_level;

  int total = 0;
  int bad   = 0;
  int exp_q[$];
  string tag_q[$];
  logic [1:0] prev_code = 2'd0;

  always #5 clk = ~clk;

  dvfs_load_governor uut (
    .clk(clk), .rst_n(rst_n), .track_en(track_en), .setpoint_turbo(setpoint_turbo),
    .cpu_busy(cpu_busy), .busy_weight(busy_weight), .gp_in(gp_in), .gp_weight(gp_weight),
    .sum_post_sel(sum_post_sel), .div_cfg(div_cfg), .ema_shift(ema_shift),
    .up_thr(up_thr), .dn_thr(dn_thr), .pnc_thr(pnc_thr), .up_cnt(up_cnt), .dn_cnt(dn_cnt),
    .req_mask(req_mask), .sw_start(sw_start), .sw_finish(sw_finish),
    .req_code(req_code), .req_irq(req_irq), .load_level(load_level)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_req(int code, string tag);
    exp_q.push_back(code);
    tag_q.push_back(tag);
  endtask

  // Scoreboard monitor: every new nonzero code must be the next predicted one.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && req_code != prev_code && req_code != 2'd0) begin
      if (exp_q.size() == 0) chk("R9 unexpected request", int'(req_code), 0);
      else chk(tag_q.pop_front(), int'(req_code), exp_q.pop_front());
    end
    prev_code = req_code;
  end

  // Reference averaging step, written with floor division.
  function automatic int ema_ref(int a, int s, int k);
    int diff = s * 16 - a;
    int p    = 1 << k;
    int step = (diff >= 0) ? diff / p : -((-diff + p - 1) / p);
    return a + step;
  endfunction

  task automatic restart();
    track_en = 1'b0;
    cyc(1);
    track_en = 1'b1;
  endtask

  task automatic close_req();
    busy_weight = 6'd25;
    sw_start = 1'b1; cyc(1); sw_start = 1'b0;
    sw_finish = 1'b1; cyc(1); sw_finish = 1'b0;
    cyc(1);
  endtask

  task automatic req_defaults();
    div_cfg = 4'd0; ema_shift = 3'd0; sum_post_sel = 1'b1;
    gp_weight = '0; gp_in = '0; cpu_busy = 1'b1;
    up_thr = 6'd31; dn_thr = 6'd18; pnc_thr = 6'd63;
    up_cnt = 8'd3; dn_cnt = 8'd3; req_mask = 1'b0; setpoint_turbo = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int exp_sum, a1, a2, a3, ass;
    rst_n = 1'b0; track_en = 1'b0; sw_start = 1'b0; sw_finish = 1'b0;
    busy_weight = '0;
    req_defaults();
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 reset code", req_code, 0);
    chk("R1 reset irq", req_irq, 0);
    chk("R1 reset load", load_level, 0);

    // Sample sum, neutral thresholds, no smoothing.
    up_thr = 6'd63; dn_thr = 6'd0; pnc_thr = 6'd63;
    busy_weight = 6'd5;
    for (int i = 0; i < 16; i++) gp_weight[i*4 +: 4] = 4'(i % 4);
    gp_in = 16'hA5A5;
    exp_sum = 5;
    for (int i = 0; i < 16; i++) if (gp_in[i]) exp_sum += i % 4;
    restart();
    cyc(2);
    chk("R2 weighted sum", load_level, exp_sum);
    gp_in = 16'h1111; cpu_busy = 1'b0;
    cyc(2);
    chk("R2 zero weights ignored", load_level, 0);
    gp_in = 16'hA5A5; cpu_busy = 1'b1; sum_post_sel = 1'b0;
    cyc(2);
    chk("R3 busy-only source", load_level, 5);
    sum_post_sel = 1'b1; gp_weight = '1; gp_in = '1; busy_weight = 6'd63;
    cyc(2);
    chk("R2 saturation", load_level, 63);
    chk("R9 no request at neutral thresholds", req_code, 0);

    // Divider and averaging.
    gp_weight = '0; gp_in = '0; busy_weight = 6'd40; div_cfg = 4'd3; ema_shift = 3'd2;
    a1 = ema_ref(0, 40, 2); a2 = ema_ref(a1, 40, 2); a3 = ema_ref(a2, 40, 2);
    restart();
    cyc(3); chk("R4 no sample before period", load_level, 0);
    cyc(1); chk("R4 first sample", load_level, a1 / 16);
    cyc(3); chk("R5 hold between samples", load_level, a1 / 16);
    cyc(1); chk("R5 second sample", load_level, a2 / 16);
    cyc(3); chk("R4 period", load_level, a2 / 16);
    cyc(1); chk("R5 third sample", load_level, a3 / 16);
    ass = 0;
    for (int i = 0; i < 200; i++) ass = ema_ref(ass, 40, 2);
    cyc(400); chk("R5 steady level", load_level, ass / 16);

    // Raise request and handshake.
    req_defaults(); busy_weight = 6'd40;
    expect_req(1, "R6 raise code");
    restart();
    cyc(3); chk("R6 not before run length", req_code, 0);
    cyc(1); chk("R6 raise fires", req_code, 1);
    chk("R10 irq raised", req_irq, 1);
    sw_finish = 1'b1; cyc(1); sw_finish = 1'b0; cyc(1);
    chk("R11 early finish ignored", req_code, 1);
    sw_start = 1'b1; cyc(1); sw_start = 1'b0;
    chk("R10 irq cleared by start", req_irq, 0);
    cyc(10); chk("R11 code held", req_code, 1);
    sw_finish = 1'b1; cyc(1); sw_finish = 1'b0;
    chk("R11 finish clears code", req_code, 0);
    expect_req(1, "R11 second raise");
    cyc(2); chk("R11 counters restart after finish", req_code, 0);
    cyc(1); chk("R11 full run after finish", req_code, 1);
    close_req();
    chk("R11 closed", req_code, 0);

    // Broken run restarts the count.
    up_cnt = 8'd4; busy_weight = 6'd25;
    restart(); cyc(3);
    busy_weight = 6'd40; cyc(3);
    busy_weight = 6'd25; cyc(1);
    busy_weight = 6'd40;
    expect_req(1, "R6 run after break");
    cyc(3); chk("R6 broken run", req_code, 0);
    cyc(2); chk("R6 fires after full run", req_code, 1);
    close_req();

    // Panic, then disable while outstanding.
    up_cnt = 8'd10; pnc_thr = 6'd50; busy_weight = 6'd55;
    expect_req(3, "R8 panic code");
    restart();
    cyc(2); chk("R8 panic on first evaluation", req_code, 3);
    track_en = 1'b0; cyc(1);
    chk("R12 disable clears code", req_code, 0);
    chk("R12 disable clears irq", req_irq, 0);
    chk("R12 disable clears load", load_level, 0);

    // Turbo: raise and panic blocked, lower allowed.
    setpoint_turbo = 1'b1; up_cnt = 8'd1; busy_weight = 6'd60;
    restart(); cyc(20);
    chk("R9 no raise in turbo", req_code, 0);
    busy_weight = 6'd10; dn_cnt = 8'd2; req_mask = 1'b1;
    expect_req(2, "R7 lower code");
    restart();
    cyc(3); chk("R7 lower fires", req_code, 2);
    chk("R10 masked irq", req_irq, 0);
    req_mask = 1'b0; cyc(1);
    chk("R10 unmasked irq", req_irq, 1);
    close_req();

    // Low setpoint: lower blocked.
    setpoint_turbo = 1'b0; busy_weight = 6'd10; dn_cnt = 8'd1; pnc_thr = 6'd63;
    restart(); cyc(20);
    chk("R9 no lower in low setpoint", req_code, 0);

    chk("R6 all predicted requests seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule